// File: doc/BRIEF.md
# Two-Codeword Pipelined Polar Successive-Cancellation Decoder

This block decodes polar codewords of length N with the successive-cancellation rule, built entirely from combinational arithmetic and cut once by a pipeline register. Each word arrives as N signed log-likelihood values plus an N-bit mask that marks which bit positions carry data. The block decides the lower N/2 bits in a half-size combinational decoder during the capture cycle. It then registers those decisions, their re-encoded partial sums, the word's full set of likelihoods and the upper half of its mask. In the next cycle a second half-size decoder finishes the upper N/2 bits of that word. Meanwhile the first decoder is already working on the following word.

Because of this split, the longest path is about that of a length-N/2 decoder, while one word still enters and one leaves per clock. A final register joins the two halves, so the output port always shows a complete decision vector that belongs to a single word. A valid flag travels through the pipeline next to the data. The mask can change on every word, so consecutive words may use different code rates.

Top module: `polar_pipe_dec`

## Requirements
- R1: While reset is held and after it is released, out_valid is 0 and out_bits is all zeros until the first decoded word leaves the pipeline.
- R2: Lane i of in_llr is the Q-bit two's-complement value at bits [i*Q +: Q]. It must lie in ±(2^(Q-1)-1). A positive value favours bit 0. A bit that is not frozen is decided as 1 exactly when its final likelihood is negative, so a value of zero gives 0.
- R3: Codeword x is formed from u by butterfly passes with stride h = 1, 2, 4, …: x[j] ^= x[j+h] for every j whose bit h is 0, so x[0] is the parity of all of u. When every likelihood has the sign of x and frozen positions of u are 0, out_bits equals u.
- R4: For arbitrary in-range likelihoods, out_bits equals a bit-serial successive-cancellation reference. That reference uses min-sum for the check node, f = sign(a)·sign(b)·min(|a|,|b|), and b + (1−2v)·a for the variable node.
- R5: A 0 in in_info at position i forces out_bits[i] to 0 whatever the likelihoods are; a 1 marks a data bit.
- R6: A word presented with in_valid high at rising edge k appears with out_valid high after edge k+2. Words may be presented on every consecutive cycle, and each one produces exactly one output word in order.
- R7: Each word is decoded with its own mask, including the upper half used one cycle later, even when the neighbouring words carry different masks.
- R8: In a cycle with no output word, out_valid is 0 and out_bits keeps the last decoded word.
- R9: Variable-node sums are clamped to ±(2^(Q-1)-1), so full-scale inputs never wrap in sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A new word is present on in_llr and in_info |
| in_llr | input | N*Q | Channel likelihoods, lane i at [i*Q +: Q] |
| in_info | input | N | Data-position mask, 1 = data bit, 0 = frozen |
| out_valid | output | 1 | out_bits holds a freshly decoded word |
| out_bits | output | N | Decided bits, bit i = u[i] |

## Verification
The bench streams words back to back and alternates all-data masks with all-frozen masks. A design that read the mask of the wrong word in the second stage would leak data bits into a frozen word, or zero out a data word. Idle gaps are placed between bursts. A design that advanced the output register without a valid word would change out_bits or raise out_valid in a gap. Full-scale and all-zero likelihoods probe the clamp and the tie rule: a wrapping sum flips decisions against the reference, and a tie that decides 1 corrupts the zero vector. Random noisy likelihoods are compared with a bit-serial reference, which exposes any mix-up between the stored likelihoods and the stored partial sums.

// File: rtl/polar_pipe_pkg.sv
package polar_pipe_pkg;

    // Check-node update: min-sum approximation on integer magnitudes.
    function automatic int cn_minsum(input int a, input int b);
        int ma;
        int mb;
        int m;
        ma = (a < 0) ? -a : a;
        mb = (b < 0) ? -b : b;
        m  = (ma < mb) ? ma : mb;
        return ((a < 0) != (b < 0)) ? -m : m;
    endfunction

    // Variable-node update b + (1-2v)*a, clamped to the symmetric q-bit range.
    function automatic int vn_clamp(input int a, input int b, input logic v, input int q);
        int lim;
        int s;
        lim = (1 << (q - 1)) - 1;
        s   = v ? (b - a) : (b + a);
        if (s > lim)  s = lim;
        if (s < -lim) s = -lim;
        return s;
    endfunction

endpackage

// File: rtl/pcd_encode.sv
module pcd_encode #(
    parameter int M = 4
) (
    input  logic [M-1:0] u,
    output logic [M-1:0] x
);

    // Butterfly passes with growing stride produce the partial-sum vector.
    always_comb begin
        logic [M-1:0] t;
        t = u;
        for (int h = 1; h < M; h = h * 2) begin
            for (int j = 0; j < M; j++) begin
                if ((j & h) == 0) begin
                    t[j] = t[j] ^ t[j + h];
                end
            end
        end
        x = t;
    end

endmodule

// File: rtl/pcd_node.sv
module pcd_node
    import polar_pipe_pkg::*;
#(
    parameter int M = 4,
    parameter int Q = 6
) (
    input  logic [M*Q-1:0] llr,
    input  logic [M-1:0]   info,
    output logic [M-1:0]   u
);

    generate
        if (M == 1) begin : g_leaf
            // Hard decision gated by the data mask; a zero likelihood decides 0.
            assign u[0] = info[0] & ($signed(llr) < 0);
        end else begin : g_split
            localparam int H = M / 2;

            logic [H*Q-1:0] cn_vec;
            logic [H*Q-1:0] vn_vec;
            logic [H-1:0]   left_u;
            logic [H-1:0]   right_u;
            logic [H-1:0]   left_ps;

            always_comb begin
                for (int j = 0; j < H; j++) begin
                    cn_vec[j*Q +: Q] = Q'(cn_minsum(int'($signed(llr[j*Q +: Q])),
                                                    int'($signed(llr[(j+H)*Q +: Q]))));
                end
            end

            pcd_node #(.M(H), .Q(Q)) u_left (
                .llr  (cn_vec),
                .info (info[H-1:0]),
                .u    (left_u)
            );

            pcd_encode #(.M(H)) u_left_ps (
                .u (left_u),
                .x (left_ps)
            );

            always_comb begin
                for (int j = 0; j < H; j++) begin
                    vn_vec[j*Q +: Q] = Q'(vn_clamp(int'($signed(llr[j*Q +: Q])),
                                                   int'($signed(llr[(j+H)*Q +: Q])),
                                                   left_ps[j], Q));
                end
            end

            pcd_node #(.M(H), .Q(Q)) u_right (
                .llr  (vn_vec),
                .info (info[M-1:H]),
                .u    (right_u)
            );

            assign u = {right_u, left_u};
        end
    endgenerate

endmodule

// File: rtl/polar_pipe_dec.sv
module polar_pipe_dec
    import polar_pipe_pkg::*;
#(
    parameter int N = 8,
    parameter int Q = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [N*Q-1:0] in_llr,
    input  logic [N-1:0]   in_info,
    output logic           out_valid,
    output logic [N-1:0]   out_bits
);

    localparam int H  = N / 2;
    localparam int HW = H * Q;

    typedef struct packed {
        logic           mid_valid;
        logic [N*Q-1:0] mid_llr;
        logic [H-1:0]   mid_ps;
        logic [H-1:0]   mid_info_hi;
        logic [H-1:0]   mid_u_lo;
        logic           out_valid;
        logic [N-1:0]   out_bits;
    } pipe_t;

    pipe_t st_d;
    pipe_t st_q;

    logic [HW-1:0] front_cn;
    logic [H-1:0]  front_u;
    logic [H-1:0]  front_ps;
    logic [HW-1:0] back_vn;
    logic [H-1:0]  back_u;

    // Front half: check-node layer on the incoming word.
    always_comb begin
        for (int j = 0; j < H; j++) begin
            front_cn[j*Q +: Q] = Q'(cn_minsum(int'($signed(in_llr[j*Q +: Q])),
                                              int'($signed(in_llr[(j+H)*Q +: Q]))));
        end
    end

    pcd_node #(.M(H), .Q(Q)) u_front (
        .llr  (front_cn),
        .info (in_info[H-1:0]),
        .u    (front_u)
    );

    pcd_encode #(.M(H)) u_front_ps (
        .u (front_u),
        .x (front_ps)
    );

    // Back half: variable-node layer on the stored word and its partial sums.
    always_comb begin
        for (int j = 0; j < H; j++) begin
            back_vn[j*Q +: Q] = Q'(vn_clamp(int'($signed(st_q.mid_llr[j*Q +: Q])),
                                            int'($signed(st_q.mid_llr[(j+H)*Q +: Q])),
                                            st_q.mid_ps[j], Q));
        end
    end

    pcd_node #(.M(H), .Q(Q)) u_back (
        .llr  (back_vn),
        .info (st_q.mid_info_hi),
        .u    (back_u)
    );

    always_comb begin
        st_d           = st_q;
        st_d.mid_valid = in_valid;
        if (in_valid) begin
            st_d.mid_llr     = in_llr;
            st_d.mid_ps      = front_ps;
            st_d.mid_info_hi = in_info[N-1:H];
            st_d.mid_u_lo    = front_u;
        end
        st_d.out_valid = st_q.mid_valid;
        if (st_q.mid_valid) begin
            st_d.out_bits = {back_u, st_q.mid_u_lo};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_valid;
    assign out_bits  = st_q.out_bits;

    AST_LATENCY_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid); // R6

    AST_LATENCY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid); // R6

    AST_FROZEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_bits & ~$past(in_info, 2)) == '0)); // R5

    AST_PS_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mid_valid |=> ((^out_bits[H-1:0]) == $past(st_q.mid_ps[0]))); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_bits)); // R8

endmodule

// File: tb/polar_pipe_dec_bench.sv
`timescale 1ns/1ps
module polar_pipe_dec_bench;

    localparam int NB  = 8;
    localparam int QW  = 6;
    localparam int LIM = (1 << (QW - 1)) - 1;

    logic            clk;
    logic            rst_n;
    logic            in_valid;
    logic [NB*QW-1:0] in_llr;
    logic [NB-1:0]   in_info;
    logic            out_valid;
    logic [NB-1:0]   out_bits;

    int n_tests;
    int n_fail;
    bit done;

    // Pipeline history of what was driven, for checking at the output.
    logic          p1_v, p2_v;
    logic [NB-1:0] p1_e, p2_e;
    string         p1_t, p2_t;
    logic [NB-1:0] held;

    polar_pipe_dec #(.N(NB), .Q(QW)) u_polar_pipe_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_llr    (in_llr),
        .in_info   (in_info),
        .out_valid (out_valid),
        .out_bits  (out_bits)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    function automatic int ref_cn(input int a, input int b);
        int ma, mb, m;
        ma = (a < 0) ? -a : a;
        mb = (b < 0) ? -b : b;
        m  = (ma < mb) ? ma : mb;
        return ((a < 0) != (b < 0)) ? -m : m;
    endfunction

    function automatic int ref_vn(input int a, input int b, input logic v);
        int s;
        s = v ? (b - a) : (b + a);
        if (s > LIM)  s = LIM;
        if (s < -LIM) s = -LIM;
        return s;
    endfunction

    function automatic logic [NB-1:0] ref_enc(input logic [NB-1:0] v, input int m);
        logic [NB-1:0] t;
        t = v;
        for (int h = 1; h < m; h = h * 2)
            for (int j = 0; j < m; j++)
                if ((j & h) == 0) t[j] = t[j] ^ t[j + h];
        return t;
    endfunction

    // Bit-serial successive cancellation, one descent per decided bit.
    function automatic logic [NB-1:0] ref_sc(input int l[NB], input logic [NB-1:0] info);
        logic [NB-1:0] u;
        logic [NB-1:0] v;
        int cur[NB];
        int len, off, b, h;
        u = '0;
        for (int i = 0; i < NB; i++) begin
            for (int k = 0; k < NB; k++) cur[k] = l[k];
            len = NB; off = 0; b = i;
            while (len > 1) begin
                h = len / 2;
                if (b < h) begin
                    for (int j = 0; j < h; j++) cur[j] = ref_cn(cur[j], cur[j + h]);
                end else begin
                    v = '0;
                    for (int j = 0; j < h; j++) v[j] = u[off + j];
                    v = ref_enc(v, h);
                    for (int j = 0; j < h; j++) cur[j] = ref_vn(cur[j], cur[j + h], v[j]);
                    off = off + h;
                    b = b - h;
                end
                len = h;
            end
            u[i] = info[i] & (cur[0] < 0);
        end
        return u;
    endfunction

    function automatic logic [NB*QW-1:0] pack(input int l[NB]);
        logic [NB*QW-1:0] p;
        for (int k = 0; k < NB; k++) p[k*QW +: QW] = QW'(l[k]);
        return p;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [NB:0] act, input logic [NB:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One clock: check the output due now, then drive the next input.
    task automatic step(input logic v, input int l[NB], input logic [NB-1:0] info,
                        input logic [NB-1:0] e, input string tag);
        @(negedge clk);
        if (p2_v) begin
            check(out_valid && out_bits == p2_e, p2_t, {out_valid, out_bits}, {1'b1, p2_e});
            held = p2_e;
        end else begin
            check(!out_valid && out_bits == held, "R8 idle hold", {out_valid, out_bits}, {1'b0, held});
        end
        p2_v = p1_v; p2_e = p1_e; p2_t = p1_t;
        p1_v = v;    p1_e = e;    p1_t = tag;
        in_valid = v;
        in_llr   = pack(l);
        in_info  = info;
    endtask

    task automatic idle(input int n);
        int z[NB];
        for (int k = 0; k < NB; k++) z[k] = 0;
        for (int c = 0; c < n; c++) step(1'b0, z, '0, '0, "idle");
    endtask

    task automatic noiseless_word(input logic [NB-1:0] info, input int mag, input string tag);
        logic [NB-1:0] u, x;
        int l[NB];
        u = NB'($urandom) & info;
        x = ref_enc(u, NB);
        for (int k = 0; k < NB; k++) begin
            int m;
            m = (mag > 0) ? mag : 1 + ($urandom % LIM);
            l[k] = x[k] ? -m : m;
        end
        step(1'b1, l, info, u, tag);
    endtask

    task automatic t_reset;
        check(!out_valid && out_bits == '0, "R1 reset state", {out_valid, out_bits}, '0);
    endtask

    task automatic t_noiseless;
        for (int w = 0; w < 12; w++) noiseless_word(NB'($urandom), 0, "R3 R6 noiseless stream");
        idle(3);
    endtask

    task automatic t_frozen;
        int l[NB];
        for (int w = 0; w < 6; w++) begin
            for (int k = 0; k < NB; k++) l[k] = int'($urandom % (2*LIM + 1)) - LIM;
            step(1'b1, l, '0, '0, "R5 all frozen");
        end
        for (int k = 0; k < NB; k++) l[k] = -LIM;
        step(1'b1, l, 8'b1110_1000, ref_sc(l, 8'b1110_1000) & 8'b1110_1000, "R5 partial mask");
        idle(3);
    endtask

    task automatic t_mixed_masks;
        for (int w = 0; w < 10; w++) begin
            if (w % 2 == 0) noiseless_word('1, 0, "R7 all-data word");
            else begin
                int l[NB];
                for (int k = 0; k < NB; k++) l[k] = -LIM;
                step(1'b1, l, '0, '0, "R7 all-frozen word");
            end
        end
        idle(3);
    endtask

    task automatic t_random;
        int l[NB];
        logic [NB-1:0] info;
        for (int w = 0; w < 60; w++) begin
            for (int k = 0; k < NB; k++) l[k] = int'($urandom % (2*LIM + 1)) - LIM;
            info = NB'($urandom);
            step(1'b1, l, info, ref_sc(l, info), "R4 R2 random vs reference");
            if (w % 13 == 12) idle(2);
        end
        idle(3);
    endtask

    task automatic t_zero;
        int l[NB];
        for (int k = 0; k < NB; k++) l[k] = 0;
        step(1'b1, l, '1, '0, "R2 zero likelihood decides 0");
        idle(3);
    endtask

    task automatic t_saturate;
        int l[NB];
        for (int w = 0; w < 6; w++) noiseless_word('1, LIM, "R9 full-scale noiseless");
        for (int w = 0; w < 6; w++) begin
            for (int k = 0; k < NB; k++) l[k] = ($urandom % 2) ? LIM : -LIM;
            l[w] = (w % 2) ? 1 : -1;
            step(1'b1, l, '1, ref_sc(l, '1), "R9 full-scale vs reference");
        end
        idle(3);
    endtask

    task automatic t_gaps;
        for (int w = 0; w < 5; w++) begin
            noiseless_word('1, 0, "R6 gapped word");
            idle(w % 3 + 1);
        end
        idle(2);
    endtask

    initial begin
        n_tests = 0; n_fail = 0; done = 1'b0;
        p1_v = 1'b0; p2_v = 1'b0; p1_e = '0; p2_e = '0; p1_t = ""; p2_t = "";
        held = '0;
        rst_n = 1'b0; in_valid = 1'b0; in_llr = '0; in_info = '0;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_noiseless;
        t_frozen;
        t_mixed_masks;
        t_random;
        t_zero;
        t_saturate;
        t_gaps;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule